// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Controller

This block sits behind a small register port and runs sense and burn operations on an array of one-time-programmable fuse words. The fuse storage is modelled inside the block. Software first picks a word through the control register. To burn, it also writes a 16-bit unlock key into that register. It then starts a sense by setting a bit in the sense-command register, or starts a burn by writing the value into the burn-data register. While an operation runs, a busy bit is set. A sense leaves its result in the result register.

Each operation drives the fuse strobe output in three phases: a relax gap, the active strobe, and a second relax gap. The lengths come from a timing register and are counted in clock cycles. A command that cannot run sets a sticky error bit, and software clears it through a clear-alias address. Burning can only turn bits from 0 to 1. The unlock key is wiped after every burn.

The register port follows valid/ready rules. A request moves when `req_valid` and `req_ready` are both high. A write takes effect at that edge and produces no response. A read returns its data one cycle later with `rsp_valid`, and `rsp_rdata` holds steady until `rsp_ready` is high. Only one read may be outstanding, so `req_ready` stays low from the moment a read is accepted until its response has been taken.

Top module: `fuse_ctl`

Register offsets on `req_addr`:
- 0: control
- 1: control clear alias
- 2: timing
- 3: sense command
- 4: burn data
- 5: sense result

Control layout:
- bits 31:16: key
- bit 9: error
- bit 8: busy
- bits 6:0: word address, equal to bank*8+word

Timing layout:
- bits 21:16: sense strobe length
- bits 15:12: relax
- bits 11:0: burn strobe length

## Requirements
- R1: After reset, the control register reads 0 (key, address, busy bit 8 and error bit 9 all clear), the timing register reads 0x0008_1010, and every fuse word senses as 0.
- R2: While a read response is pending and `rsp_ready` is low, `rsp_valid` stays high, `rsp_rdata` stays unchanged, and `req_ready` stays low.
- R3: Writing a 1 to bit 0 at offset 3 senses the addressed word. Busy (control bit 8) stays high until the sense ends, and then offset 5 holds the stored word.
- R4: Writing offset 4 while the key field equals 0x3E77 burns the addressed word. The word becomes the old value OR the written value.
- R5: Writing offset 4 when the key is not 0x3E77 starts nothing, leaves the strobe low and the storage unchanged, and sets error bit 9.
- R6: A sense or burn command issued while busy is high is refused: the stored word is unchanged and error bit 9 is set.
- R7: The error bit is sticky. Writing offset 1 with bit 9 set clears it. Writing offset 1 with bit 9 clear does nothing, and neither write changes the key or the address.
- R8: When a burn completes, the key field reads 0, so each burn needs a fresh unlock.
- R9: With relax field R and strobe length S (the sense length for a sense, the burn length for a burn), the strobe rises R+1 cycles after the command edge and stays high for S-2*(R+1) cycles.
- R10: If S is not larger than 2*(R+1), the strobe stays high for exactly one cycle.
- R11: The 7-bit address selects one of 128 words, each independent: a burn changes only the addressed word.
- R12: Writes to offsets 0 and 2 while busy is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 32 | Read data |
| fuse_strobe | output | 1 | Active strobe to the fuse array |

## Verification
The bench builds the block with its default parameters: 16 banks of 8 words and default timing of 8/1/16. This lets it reach the first and the last word address. The default timing register can also be read straight after reset. The bench rewrites the timing register at run time to reach the other cases: a long burn window, in which commands and register writes can be issued during busy, and a relax setting large enough to push the strobe into its one-cycle clamp.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;
  localparam int BUS_W   = 32;
  localparam int KEY_W   = 16;
  localparam int RLX_W   = 4;
  localparam int SRD_W   = 6;
  localparam int SPG_W   = 12;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_CLR    = 3'd1;
  localparam logic [2:0] OFS_TIMING = 3'd2;
  localparam logic [2:0] OFS_SENSE  = 3'd3;
  localparam logic [2:0] OFS_BURN   = 3'd4;
  localparam logic [2:0] OFS_RESULT = 3'd5;

  localparam int BIT_BUSY = 8;
  localparam int BIT_ERR  = 9;

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_ACT, PH_POST} seq_phase_e;
endpackage

// File: rtl/fuse_store.sv
module fuse_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burn_en,
  input  logic [AW-1:0]     burn_addr,
  input  logic [DATA_W-1:0] burn_data,
  input  logic [AW-1:0]     look_addr,
  output logic [DATA_W-1:0] look_data
);
  logic [DEPTH-1:0][DATA_W-1:0] cells;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else if (burn_en && (burn_addr == AW'(g))) word_q <= word_q | burn_data;
      end
      assign cells[g] = word_q;

      // R4: a fuse bit once set never returns to 0
      p_bits_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((word_q & $past(word_q)) == $past(word_q)));
    end
  endgenerate

  assign look_data = cells[look_addr];
endmodule

// File: rtl/fuse_pulse_seq.sv
module fuse_pulse_seq
  import fuse_ctl_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int RL_W  = 4,
  localparam int SUM_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [RL_W-1:0]  relax_len,
  input  logic [LEN_W-1:0] strobe_len,
  output logic             busy,
  output logic             strobe,
  output logic             done
);
  seq_phase_e       phase_q;
  logic [LEN_W-1:0] cnt_q, act_q;
  logic [RL_W-1:0]  rlx_q;
  logic [SUM_W-1:0] guard, span;

  assign guard = (SUM_W'(relax_len) + SUM_W'(1)) << 1;
  assign span  = (SUM_W'(strobe_len) > guard) ? (SUM_W'(strobe_len) - guard) : SUM_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      rlx_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (go) begin
          phase_q <= PH_PRE;
          cnt_q   <= LEN_W'(relax_len);
          rlx_q   <= relax_len;
          act_q   <= span[LEN_W-1:0];
        end
        PH_PRE: if (cnt_q == '0) begin
          phase_q <= PH_ACT;
          cnt_q   <= act_q - LEN_W'(1);
        end else cnt_q <= cnt_q - LEN_W'(1);
        PH_ACT: if (cnt_q == '0) begin
          phase_q <= PH_POST;
          cnt_q   <= LEN_W'(rlx_q);
        end else cnt_q <= cnt_q - LEN_W'(1);
        default: if (cnt_q == '0) phase_q <= PH_IDLE;
                 else cnt_q <= cnt_q - LEN_W'(1);
      endcase
    end
  end

  assign busy   = (phase_q != PH_IDLE);
  assign strobe = (phase_q == PH_ACT);
  assign done   = (phase_q == PH_POST) && (cnt_q == '0);

  // R6: the controller only launches when the sequencer is idle
  p_go_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (phase_q == PH_IDLE));
  // R9: the strobe is entered only from the leading relax gap
  p_strobe_after_relax_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> ($past(phase_q) == PH_PRE));
  // R3: completion releases busy on the next cycle
  p_done_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
  import fuse_ctl_pkg::*;
#(
  parameter int BANKS = 16,
  parameter int WORDS = 8,
  parameter logic [SRD_W-1:0] DEF_SREAD = 6'd8,
  parameter logic [RLX_W-1:0] DEF_RELAX = 4'd1,
  parameter logic [SPG_W-1:0] DEF_SPROG = 12'd16,
  localparam int DEPTH = BANKS * WORDS,
  localparam int FA_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [2:0]       req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [BUS_W-1:0] rsp_rdata,
  output logic             fuse_strobe
);
  logic [KEY_W-1:0] key_q;
  logic [FA_W-1:0]  addr_q;
  logic             err_q, op_burn_q;
  logic [SRD_W-1:0] sread_q;
  logic [RLX_W-1:0] relax_q;
  logic [SPG_W-1:0] sprog_q;
  logic [BUS_W-1:0] burn_val_q, result_q, rsp_q;
  logic             rsp_v_q;

  logic accept, wr, rd, sense_cmd, burn_cmd, start_sense, start_burn, refuse, clr_hit;
  logic seq_busy, seq_done;
  logic [SPG_W-1:0] sel_len;
  logic [BUS_W-1:0] store_word, ctrl_img, timing_img, rd_mux;

  assign req_ready   = !rsp_v_q;
  assign accept      = req_valid && req_ready;
  assign wr          = accept && req_write;
  assign rd          = accept && !req_write;
  assign sense_cmd   = wr && (req_addr == OFS_SENSE) && req_wdata[0];
  assign burn_cmd    = wr && (req_addr == OFS_BURN);
  assign start_sense = sense_cmd && !seq_busy;
  assign start_burn  = burn_cmd && !seq_busy && (key_q == UNLOCK_KEY);
  assign refuse      = (sense_cmd || burn_cmd) && !(start_sense || start_burn);
  assign clr_hit     = wr && (req_addr == OFS_CLR) && req_wdata[BIT_ERR];
  assign sel_len     = start_burn ? sprog_q : SPG_W'(sread_q);

  fuse_pulse_seq #(.LEN_W(SPG_W), .RL_W(RLX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(start_sense || start_burn),
    .relax_len(relax_q), .strobe_len(sel_len),
    .busy(seq_busy), .strobe(fuse_strobe), .done(seq_done)
  );

  fuse_store #(.DATA_W(BUS_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .burn_en(seq_done && op_burn_q), .burn_addr(addr_q), .burn_data(burn_val_q),
    .look_addr(addr_q), .look_data(store_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0; addr_q <= '0; err_q <= 1'b0; op_burn_q <= 1'b0;
      sread_q <= DEF_SREAD; relax_q <= DEF_RELAX; sprog_q <= DEF_SPROG;
      burn_val_q <= '0; result_q <= '0;
    end else begin
      if (wr && !seq_busy && (req_addr == OFS_CTRL)) begin
        key_q  <= req_wdata[31:16];
        addr_q <= req_wdata[FA_W-1:0];
      end
      if (wr && !seq_busy && (req_addr == OFS_TIMING)) begin
        sread_q <= req_wdata[21:16];
        relax_q <= req_wdata[15:12];
        sprog_q <= req_wdata[11:0];
      end
      if (burn_cmd && !seq_busy) burn_val_q <= req_wdata;
      if (start_sense) op_burn_q <= 1'b0;
      if (start_burn)  op_burn_q <= 1'b1;
      if (seq_done) begin
        if (op_burn_q) key_q <= '0;
        else result_q <= store_word;
      end
      if (refuse) err_q <= 1'b1;
      else if (clr_hit) err_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_img = '0;
    ctrl_img[31:16]    = key_q;
    ctrl_img[BIT_ERR]  = err_q;
    ctrl_img[BIT_BUSY] = seq_busy;
    ctrl_img[FA_W-1:0] = addr_q;
    timing_img = '0;
    timing_img[21:16] = sread_q;
    timing_img[15:12] = relax_q;
    timing_img[11:0]  = sprog_q;
    case (req_addr)
      OFS_CTRL, OFS_CLR: rd_mux = ctrl_img;
      OFS_TIMING:        rd_mux = timing_img;
      OFS_BURN:          rd_mux = burn_val_q;
      OFS_RESULT:        rd_mux = result_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else if (rd) begin
      rsp_v_q <= 1'b1;
      rsp_q   <= rd_mux;
    end else if (rsp_v_q && rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_q;

  // R2: a stalled response holds its data
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R6: a command that meets a busy sequencer raises the error
  p_busy_cmd_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && (sense_cmd || burn_cmd)) |=> err_q);
  // R7: error only falls through the clear alias
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_hit) |=> err_q);
  // R8: burn completion wipes the key
  p_key_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && op_burn_q) |=> (key_q == '0));
  // R12: control address stays put while busy
  p_addr_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && $past(seq_busy)) |-> $stable(addr_q));
endmodule

// File: tb/fuse_ctl_bench.sv
module fuse_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, fuse_strobe;
  logic [31:0] rsp_rdata;

  always #2.5 clk = ~clk;

  fuse_ctl u_fuse_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .fuse_strobe(fuse_strobe)
  );

  typedef struct {logic [31:0] exp; bit chk; string tag;} item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  logic [31:0] last_rd;
  bit done_flag = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as responses are taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready && sb.size() != 0) begin
      item_t it;
      it = sb.pop_front();
      last_rd = rsp_rdata;
      if (it.chk) check(rsp_rdata === it.exp, it.tag, rsp_rdata, it.exp);
    end
  end

  task automatic issue(input bit w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    issue(1'b1, a, d);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.chk = 1'b1; it.tag = tag;
    sb.push_back(it);
    issue(1'b0, a, '0);
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    item_t it;
    it.exp = '0; it.chk = 1'b0; it.tag = "peek";
    sb.push_back(it);
    issue(1'b0, a, '0);
    while (sb.size() != 0) @(negedge clk);
    v = last_rd;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin peek(3'd0, v); n++; end while (v[8] && n < 2000);
  endtask

  task automatic sense(input logic [6:0] a, input logic [31:0] exp, input string tag);
    wr(3'd0, {16'h0000, 9'd0, a});
    wr(3'd3, 32'd1);
    wait_idle();
    rd(3'd5, exp, tag);
  endtask

  // measure strobe delay and width after a command write returns
  task automatic measure(output int dly, output int wid);
    dly = 0; wid = 0;
    while (!fuse_strobe && dly < 200) begin @(negedge clk); dly++; end
    while (fuse_strobe && wid < 5000) begin wid++; @(negedge clk); end
  endtask

  initial begin
    int d, w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 port idle", {30'd0, rsp_valid, req_ready}, 32'd1);
    rd(3'd0, 32'h0000_0000, "R1 ctrl reset");
    rd(3'd2, 32'h0008_1010, "R1 timing default");
    sense(7'd0, 32'h0, "R1 storage zero");

    // R9 timing: sread=12 relax=2 sprog=20
    wr(3'd2, 32'h000C_2014);
    rd(3'd2, 32'h000C_2014, "R9 timing readback");

    // R4 burn bank3 word5 = 29, R11 address
    wr(3'd0, 32'h3E77_001D);
    wr(3'd4, 32'h0000_00F0);
    measure(d, w);
    check(d == 3, "R9 burn strobe delay", d, 3);
    check(w == 14, "R9 burn strobe width", w, 14);
    wait_idle();
    rd(3'd0, 32'h0000_001D, "R8 key wiped after burn");
    wr(3'd3, 32'd1);
    measure(d, w);
    check(d == 3, "R9 sense strobe delay", d, 3);
    check(w == 6, "R9 sense strobe width", w, 6);
    wait_idle();
    rd(3'd5, 32'h0000_00F0, "R3 sense result");
    wr(3'd0, 32'h3E77_001D);
    wr(3'd4, 32'h0F00_0001);
    wait_idle();
    sense(7'd29, 32'h0F00_00F1, "R4 burn ORs");
    sense(7'd28, 32'h0, "R11 neighbour untouched");
    wr(3'd0, 32'h3E77_007F);
    wr(3'd4, 32'h0000_A5A5);
    wait_idle();
    sense(7'd127, 32'h0000_A5A5, "R11 last word");
    sense(7'd0, 32'h0, "R11 first word untouched");

    // R5 wrong key
    wr(3'd0, 32'h1234_0005);
    wr(3'd4, 32'hFFFF_FFFF);
    d = 0;
    repeat (8) begin @(negedge clk); if (fuse_strobe) d++; end
    check(d == 0, "R5 no strobe", d, 0);
    rd(3'd0, 32'h1234_0205, "R5 error set");
    // R7 clear alias
    wr(3'd1, 32'h0000_0000);
    rd(3'd0, 32'h1234_0205, "R7 zero write keeps error");
    wr(3'd1, 32'h0000_0200);
    rd(3'd0, 32'h1234_0005, "R7 error cleared, fields kept");
    sense(7'd5, 32'h0, "R5 storage unchanged");

    // R6 / R12 commands and writes during busy
    wr(3'd2, 32'h000C_2028);
    wr(3'd0, 32'h3E77_000A);
    wr(3'd4, 32'h0000_0003);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'h0000_00FF);
    wr(3'd0, 32'h3E77_0014);
    wr(3'd2, 32'h0001_1111);
    rd(3'd0, 32'h3E77_030A, "R12 ctrl frozen while busy");
    wait_idle();
    rd(3'd0, 32'h0000_020A, "R6 error after busy command");
    rd(3'd2, 32'h000C_2028, "R12 timing write dropped");
    wr(3'd1, 32'h0000_0200);
    sense(7'd10, 32'h0000_0003, "R6 refused burn left word");

    // R10 clamp: sread=4 relax=5
    wr(3'd2, 32'h0004_5028);
    wr(3'd0, 32'h0000_001D);
    wr(3'd3, 32'd1);
    measure(d, w);
    check(d == 6, "R10 clamp delay", d, 6);
    check(w == 1, "R10 clamp width", w, 1);
    wait_idle();
    rd(3'd5, 32'h0F00_00F1, "R10 clamped sense result");

    // R2 back-pressure on the response
    begin
      item_t it;
      it.exp = 32'h0004_5028; it.chk = 1'b1; it.tag = "R2 stalled data";
      sb.push_back(it);
      @(negedge clk);
      rsp_ready = 1'b0;
      issue(1'b0, 3'd2, '0);
      repeat (3) begin
        check(rsp_valid === 1'b1 && req_ready === 1'b0, "R2 stall held",
              {30'd0, rsp_valid, req_ready}, 32'd2);
        check(rsp_rdata === 32'h0004_5028, "R2 data stable", rsp_rdata, 32'h0004_5028);
        @(negedge clk);
      end
      rsp_ready = 1'b1;
      while (sb.size() != 0) @(negedge clk);
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule